// File: doc/BRIEF.md
# Dual-Port Arbitrated Mailbox

The mailbox gives a host-side bus agent and a local processor a shared bank of sixteen byte-wide registers. Each side has its own single-cycle write port (write enable, address, data) and a read port that answers combinationally for the address it presents. Index 0 is special: each side owns a private copy of it. Writing that copy is how a side claims the mailbox.

When nobody holds the access rights, the first side whose write to index 0 is accepted becomes the owner. If both write in the same cycle, the host wins. While a side owns the mailbox, its copy of index 0 is what both sides read at address 0. The other side's writes to its own copy are dropped. Only the owner may update indexes 1 to 15, and both sides can read them at any time. Each side gets a write-valid flag that tells its software whether its last index-0 write counted. The owner gives up the rights by pulsing its release input.

Top module: `mbx_dualport_mailbox`

## Requirements
- R1: After reset every register reads 0 on both ports, neither side owns the mailbox and both write-valid flags are 0.
- R2: With no owner, a write to index 0 from one side alone is accepted, and from the next cycle that side's owns output is 1.
- R3: With no owner, when both sides write index 0 in the same cycle, the host becomes the owner and only the host's copy is updated.
- R4: While the host owns the mailbox, a slave read of address 0 returns the host's copy of index 0.
- R5: While the host owns the mailbox, a slave write to index 0 leaves the slave's copy unchanged.
- R6: While the slave owns the mailbox, a host read of address 0 returns the slave's copy of index 0.
- R7: While the slave owns the mailbox, a host write to index 0 leaves the host's copy unchanged.
- R8: A side's write-valid flag goes to 1 when its index-0 write is accepted. It goes to 0 when the other side gains the rights. The two flags are never both 1.
- R9: The owner's release pulse returns the mailbox to no owner on the next cycle. A release pulse from the side that does not own it has no effect.
- R10: Indexes 1 to 15 change only on a write from the current owner. With no owner, writes to them are ignored. Both ports read them at all times.
- R11: With no owner, each side reads its own copy at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register index (read and write) |
| host_wdata | input | 8 | Host write data |
| host_rel | input | 1 | Host release pulse |
| host_rdata | output | 8 | Host read data for host_addr |
| host_wvalid | output | 1 | Host's last index-0 write was accepted |
| host_owns | output | 1 | Host holds the access rights |
| slv_we | input | 1 | Slave write strobe |
| slv_addr | input | 4 | Slave register index (read and write) |
| slv_wdata | input | 8 | Slave write data |
| slv_rel | input | 1 | Slave release pulse |
| slv_rdata | output | 8 | Slave read data for slv_addr |
| slv_wvalid | output | 1 | Slave's last index-0 write was accepted |
| slv_owns | output | 1 | Slave holds the access rights |

## Verification
The hardest case to reach is the exact-cycle race: both sides write index 0 on the same edge while the mailbox is free. A close second is a release that lands in the same cycle as the other side's claim attempt. Random traffic seldom lines these up, so the stimulus aims at them directly. A directed phase forces a same-cycle tie and then releases. A random phase biases both addresses heavily toward index 0 and pulses release often, so that free-mailbox races come up again and again. A cycle-level model in the bench checks every output throughout.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_SLV  = 2'd2
  } owner_e;

  // A side sees the peer's index-0 copy only while the peer owns the mailbox.
  function automatic logic show_peer(input owner_e own, input logic is_host);
    return is_host ? (own == OWN_SLV) : (own == OWN_HOST);
  endfunction

  // Whether an index-0 write from a side is accepted this cycle.
  // Free mailbox: host always accepted, slave only if host is not racing.
  function automatic logic r0_accept(input owner_e own, input logic is_host,
                                     input logic peer_r0_wr);
    if (own == OWN_NONE) return is_host ? 1'b1 : !peer_r0_wr;
    return is_host ? (own == OWN_HOST) : (own == OWN_SLV);
  endfunction

endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
  import mbx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   h_r0_wr,
  input  logic   s_r0_wr,
  input  logic   h_rel,
  input  logic   s_rel,
  output owner_e owner_q,
  output logic   h_acc,
  output logic   s_acc,
  output logic   h_wv_q,
  output logic   s_wv_q
);

  logic   h_grant, s_grant, rel_evt;
  owner_e owner_d;

  assign h_acc   = h_r0_wr && r0_accept(owner_q, 1'b1, s_r0_wr);
  assign s_acc   = s_r0_wr && r0_accept(owner_q, 1'b0, h_r0_wr);
  assign h_grant = (owner_q == OWN_NONE) && h_acc;
  assign s_grant = (owner_q == OWN_NONE) && s_acc;
  assign rel_evt = ((owner_q == OWN_HOST) && h_rel) ||
                   ((owner_q == OWN_SLV)  && s_rel);

  always_comb begin
    owner_d = owner_q;
    if (rel_evt)      owner_d = OWN_NONE;
    else if (h_grant) owner_d = OWN_HOST;
    else if (s_grant) owner_d = OWN_SLV;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      h_wv_q  <= 1'b0;
      s_wv_q  <= 1'b0;
    end else begin
      owner_q <= owner_d;
      if (s_grant)    h_wv_q <= 1'b0;
      else if (h_acc) h_wv_q <= 1'b1;
      if (h_grant)    s_wv_q <= 1'b0;
      else if (s_acc) s_wv_q <= 1'b1;
    end
  end

  assert_tie_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE && h_r0_wr && s_r0_wr) |=> (owner_q == OWN_HOST));

  assert_slave_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE && s_r0_wr && !h_r0_wr) |=> (owner_q == OWN_SLV));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_wv_q && s_wv_q));

  assert_hold_rights_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_HOST && !h_rel) |=> (owner_q == OWN_HOST));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_SLV && s_rel) |=> (owner_q == OWN_NONE));

endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  owner_e                   owner,
  input  logic                     h_acc,
  input  logic                     s_acc,
  input  logic                     h_we,
  input  logic [AW-1:0]            h_addr,
  input  logic [DW-1:0]            h_wdata,
  input  logic                     s_we,
  input  logic [AW-1:0]            s_addr,
  input  logic [DW-1:0]            s_wdata,
  output logic [DW-1:0]            r0_host_q,
  output logic [DW-1:0]            r0_slv_q,
  output logic [NREG-1:1][DW-1:0]  regs_q
);

  logic h_bank_wr, s_bank_wr;

  assign h_bank_wr = (owner == OWN_HOST) && h_we && (h_addr != '0);
  assign s_bank_wr = (owner == OWN_SLV)  && s_we && (s_addr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r0_host_q <= '0;
      r0_slv_q  <= '0;
    end else begin
      if (h_acc) r0_host_q <= h_wdata;
      if (s_acc) r0_slv_q  <= s_wdata;
    end
  end

  for (genvar k = 1; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                regs_q[k] <= '0;
      else if (h_bank_wr && h_addr == AW'(k))    regs_q[k] <= h_wdata;
      else if (s_bank_wr && s_addr == AW'(k))    regs_q[k] <= s_wdata;
    end
  end

  assert_slave_r0_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_HOST) |=> $stable(r0_slv_q));

  assert_host_r0_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_SLV) |=> $stable(r0_host_q));

  assert_free_bank_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE) |=> $stable(regs_q));

endmodule

// File: rtl/mbx_rdport.sv
module mbx_rdport
  import mbx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NREG    = 16,
  parameter bit IS_HOST = 1'b1,
  localparam int AW     = $clog2(NREG)
) (
  input  owner_e                   owner,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            r0_mine,
  input  logic [DW-1:0]            r0_peer,
  input  logic [NREG-1:1][DW-1:0]  regs,
  output logic [DW-1:0]            rdata
);

  always_comb begin
    rdata = show_peer(owner, IS_HOST) ? r0_peer : r0_mine;
    for (int k = 1; k < NREG; k++) begin
      if (addr == AW'(k)) rdata = regs[k];
    end
  end

endmodule

// File: rtl/mbx_dualport_mailbox.sv
module mbx_dualport_mailbox
  import mbx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rel,
  output logic [DW-1:0] host_rdata,
  output logic          host_wvalid,
  output logic          host_owns,
  input  logic          slv_we,
  input  logic [AW-1:0] slv_addr,
  input  logic [DW-1:0] slv_wdata,
  input  logic          slv_rel,
  output logic [DW-1:0] slv_rdata,
  output logic          slv_wvalid,
  output logic          slv_owns
);

  // Named internal events for the assertions.
  logic                    h_r0_wr, s_r0_wr, h_acc, s_acc;
  owner_e                  owner;
  logic [DW-1:0]           r0_host, r0_slv;
  logic [NREG-1:1][DW-1:0] regs;

  assign h_r0_wr = host_we && (host_addr == '0);
  assign s_r0_wr = slv_we  && (slv_addr  == '0);

  mbx_arbiter u_arb (
    .clk, .rst_n,
    .h_r0_wr, .s_r0_wr,
    .h_rel(host_rel), .s_rel(slv_rel),
    .owner_q(owner), .h_acc, .s_acc,
    .h_wv_q(host_wvalid), .s_wv_q(slv_wvalid)
  );

  mbx_store #(.DW(DW), .NREG(NREG)) u_store (
    .clk, .rst_n, .owner, .h_acc, .s_acc,
    .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata),
    .s_we(slv_we),  .s_addr(slv_addr),  .s_wdata(slv_wdata),
    .r0_host_q(r0_host), .r0_slv_q(r0_slv), .regs_q(regs)
  );

  mbx_rdport #(.DW(DW), .NREG(NREG), .IS_HOST(1'b1)) u_rd_host (
    .owner, .addr(host_addr), .r0_mine(r0_host), .r0_peer(r0_slv),
    .regs, .rdata(host_rdata)
  );

  mbx_rdport #(.DW(DW), .NREG(NREG), .IS_HOST(1'b0)) u_rd_slv (
    .owner, .addr(slv_addr), .r0_mine(r0_slv), .r0_peer(r0_host),
    .regs, .rdata(slv_rdata)
  );

  assign host_owns = (owner == OWN_HOST);
  assign slv_owns  = (owner == OWN_SLV);

  assert_view_host_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_owns && slv_addr == '0) |-> (slv_rdata == host_rdata || host_addr != '0));

  assert_view_slave_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_owns && host_addr == '0 && slv_addr == '0) |-> (host_rdata == slv_rdata));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!host_owns && !slv_owns && !host_wvalid && !slv_wvalid));

endmodule

// File: tb/mbx_dualport_mailbox_tb_top.sv
module mbx_dualport_mailbox_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 0, slv_we = 0, host_rel = 0, slv_rel = 0;
  logic [3:0] host_addr = 0, slv_addr = 0;
  logic [7:0] host_wdata = 0, slv_wdata = 0;
  logic [7:0] host_rdata, slv_rdata;
  logic       host_wvalid, host_owns, slv_wvalid, slv_owns;

  always #2 clk = ~clk;

  mbx_dualport_mailbox dut_i (
    .clk, .rst_n,
    .host_we, .host_addr, .host_wdata, .host_rel,
    .host_rdata, .host_wvalid, .host_owns,
    .slv_we, .slv_addr, .slv_wdata, .slv_rel,
    .slv_rdata, .slv_wvalid, .slv_owns
  );

  // Reference model: 0 = free, 1 = host, 2 = slave
  int       m_own;
  bit [7:0] m_r0h, m_r0s;
  bit [7:0] m_bank [16];
  bit       m_hwv, m_swv;
  int       n_cmp = 0, n_bad = 0;

  task automatic model_reset();
    m_own = 0; m_r0h = 0; m_r0s = 0; m_hwv = 0; m_swv = 0;
    foreach (m_bank[i]) m_bank[i] = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit h0, s0, hacc, sacc;
      int nown;
      h0   = host_we && host_addr == 0;
      s0   = slv_we  && slv_addr  == 0;
      hacc = h0 && (m_own == 1 || m_own == 0);
      sacc = s0 && (m_own == 2 || (m_own == 0 && !h0));
      if (m_own == 1 && host_we && host_addr != 0) m_bank[host_addr] = host_wdata;
      if (m_own == 2 && slv_we  && slv_addr  != 0) m_bank[slv_addr]  = slv_wdata;
      if (hacc) m_r0h = host_wdata;
      if (sacc) m_r0s = slv_wdata;
      nown = m_own;
      if (m_own == 0 && hacc)      nown = 1;
      else if (m_own == 0 && sacc) nown = 2;
      if (m_own == 1 && host_rel)  nown = 0;
      if (m_own == 2 && slv_rel)   nown = 0;
      if (hacc) m_hwv = 1;
      if (sacc) m_swv = 1;
      if (m_own == 0 && nown == 2) m_hwv = 0;
      if (m_own == 0 && nown == 1) m_swv = 0;
      m_own = nown;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at the falling edge: compare every output against the model.
  task automatic compare_all();
    bit [7:0] eh, es;
    string th, ts;
    eh = (host_addr == 0) ? ((m_own == 2) ? m_r0s : m_r0h) : m_bank[host_addr];
    es = (slv_addr  == 0) ? ((m_own == 1) ? m_r0h : m_r0s) : m_bank[slv_addr];
    th = (host_addr != 0) ? "R10 host read" : (m_own == 2) ? "R6 host read r0" : "R11 host read r0";
    ts = (slv_addr  != 0) ? "R10 slave read" : (m_own == 1) ? "R4 slave read r0" : "R11 slave read r0";
    chk(th, host_rdata, eh);
    chk(ts, slv_rdata, es);
    chk("R2/R9 host_owns", host_owns, m_own == 1);
    chk("R2/R9 slv_owns", slv_owns, m_own == 2);
    chk("R8 host_wvalid", host_wvalid, m_hwv);
    chk("R8 slv_wvalid", slv_wvalid, m_swv);
  endtask

  task automatic step(bit hwe, int ha, int hd, bit hr, bit swe, int sa, int sd, bit sr);
    @(negedge clk);
    compare_all();
    host_we = hwe; host_addr = 4'(ha); host_wdata = 8'(hd); host_rel = hr;
    slv_we  = swe; slv_addr  = 4'(sa); slv_wdata  = 8'(sd); slv_rel  = sr;
  endtask

  task automatic idle_read(int ha, int sa);
    step(0, ha, 0, 0, 0, sa, 0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen on both ports at several addresses
    idle_read(0, 0); idle_read(5, 15); idle_read(15, 1);
    // R10: writes to bank with no owner are ignored
    step(1, 3, 8'h11, 0, 1, 4, 8'h22, 0);
    idle_read(3, 4);
    // R3: same-cycle race, host wins
    step(1, 0, 8'hA5, 0, 1, 0, 8'h5A, 0);
    idle_read(0, 0);
    // R5: slave write to r0 while host owns is dropped
    step(0, 0, 0, 0, 1, 0, 8'h77, 0);
    step(1, 7, 8'hC3, 0, 0, 7, 0, 0);
    idle_read(7, 0);
    // R9: non-owner release does nothing, then host releases
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    idle_read(0, 0);
    // R2: slave claims alone; R7 host write dropped; R6 host sees slave copy
    step(0, 0, 0, 0, 1, 0, 8'h3C, 0);
    step(1, 0, 8'h99, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 9, 8'h4D, 0);
    idle_read(9, 9);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    idle_read(0, 0);
    // Random phase biased toward r0 races and frequent release
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step($urandom_range(0, 99) < 50, (r < 50) ? 0 : $urandom_range(1, 15),
           $urandom_range(0, 255), $urandom_range(0, 99) < 12,
           $urandom_range(0, 99) < 50, ($urandom_range(0, 99) < 50) ? 0 : $urandom_range(1, 15),
           $urandom_range(0, 255), $urandom_range(0, 99) < 12);
    end
    idle_read(0, 0);
    idle_read(0, 0);
    summary();
    $finish;
  end

endmodule